// File: doc/BRIEF.md
# Interrupt Pending and Priority Controller

This block gathers interrupt requests for a processor core into a pending field. Two software-owned bits sit at the bottom of the field and are set or cleared by register writes. Above them sit eleven hardware request lines. Each hardware line is asynchronous, passes through a two-flop synchronizer, and its level is mirrored into its own pending bit. The pending field is ANDed with a local-enable mask register. The block then decides whether the core may take an interrupt. Taking one needs the global enable to be high and the core to be out of debug mode.

When an interrupt may be taken, the block raises a one-cycle take strobe. On the same cycle it presents the index of the highest-numbered enabled pending bit as the vector. The vector then holds still until the exception entry logic returns an acknowledge. A wake flag tells an idle core that work is waiting. It depends only on the masked pending value and disregards the global enable and debug mode. The exception entry logic is outside this block: it computes the entry address and saves the machine state.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the software pending bits (field bits 0 and 1), the hardware pending bits and the local-enable mask are all zero, and take_o and wake_o are low; software bits written right after reset do not raise wake_o because the mask is still zero.
- R2: Hardware line i drives pending bit 2+i with its level; a change on the line is visible on pend_o after two rising clock edges and not after one, and the bit falls again when the line drops.
- R3: A cycle with sw_wr_en_i high loads sw_wr_data_i into pending bits 1:0 at the next edge; software writes leave the hardware pending bits unchanged, and without a write the software bits keep their value.
- R4: take_o is raised only when glb_ie_i is 1, dbg_mode_i is 0 and the masked pending value is nonzero; with debug mode set no take occurs even with the global enable on.
- R5: The vector presented with take_o is the index of the most significant set bit of the masked pending value.
- R6: take_o is a registered pulse lasting exactly one cycle, and vec_o is valid in that same cycle.
- R7: After a take, vec_o stays stable and no further take occurs until ack_i is sampled high.
- R8: wake_o is high exactly when the masked pending value is nonzero, whatever glb_ie_i and dbg_mode_i are.
- R9: A cycle with mask_wr_en_i high loads mask_wr_data_i into the local-enable mask; pending bits whose mask bit is 0 neither raise wake_o nor cause a take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hw_req_i | input | 11 | Asynchronous level-sensitive hardware request lines |
| sw_wr_en_i | input | 1 | Write strobe for the software pending bits |
| sw_wr_data_i | input | 2 | New value of the software pending bits |
| mask_wr_en_i | input | 1 | Write strobe for the local-enable mask |
| mask_wr_data_i | input | 13 | New value of the local-enable mask |
| glb_ie_i | input | 1 | Global interrupt enable |
| dbg_mode_i | input | 1 | Core is in debug mode |
| ack_i | input | 1 | Entry logic has consumed the vector |
| take_o | output | 1 | One-cycle take-interrupt strobe |
| vec_o | output | 4 | Index of the chosen source |
| wake_o | output | 1 | Enabled interrupt pending, for an idle core |
| pend_o | output | 13 | Pending field, hardware bits above software bits |

## Verification
The assertions assume that glb_ie_i, dbg_mode_i, ack_i and both write strobes are synchronous to clk. They also assume that ack_i comes only while a vector is held. The stimulus changes every input on the falling edge. It raises ack_i only after a take has been seen, and it drops the global enable before each acknowledge, so that each expected take lines up with exactly one scoreboard entry. The hardware lines are the only inputs that are treated as asynchronous. The bench still drives them on the falling edge, so the two-edge latency can be counted exactly.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic {
    TK_IDLE = 1'b0,
    TK_HOLD = 1'b1
  } take_state_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 11,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = async_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int NUM_SW    = 2,
  parameter int NUM_LINES = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sw_wr_en_i,
  input  logic [NUM_SW-1:0]    sw_wr_data_i,
  input  logic                 mask_wr_en_i,
  input  logic [NUM_LINES-1:0] mask_wr_data_i,
  output logic [NUM_SW-1:0]    sw_q_o,
  output logic [NUM_LINES-1:0] mask_q_o
);
  logic [NUM_SW-1:0]    sw_d, sw_q;
  logic [NUM_LINES-1:0] mask_d, mask_q;

  always_comb begin
    sw_d   = sw_q;
    mask_d = mask_q;
    if (sw_wr_en_i)   sw_d   = sw_wr_data_i;
    if (mask_wr_en_i) mask_d = mask_wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q   <= '0;
      mask_q <= '0;
    end else begin
      sw_q   <= sw_d;
      mask_q <= mask_d;
    end
  end

  assign sw_q_o   = sw_q;
  assign mask_q_o = mask_q;

  AST_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_en_i |=> $stable(sw_q_o)); // R3
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr_en_i |=> $stable(mask_q_o)); // R9
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_LINES = 13,
  parameter int VEC_W     = 4
) (
  input  logic [NUM_LINES-1:0] masked_i,
  output logic                 any_o,
  output logic [VEC_W-1:0]     idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (masked_i[i]) idx_o = VEC_W'(i);
    end
  end

  assign any_o = |masked_i;
endmodule

// File: rtl/irq_take_ctrl.sv
module irq_take_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_LINES = 13,
  parameter int VEC_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 glb_ie_i,
  input  logic                 dbg_mode_i,
  input  logic                 any_i,
  input  logic [VEC_W-1:0]     idx_i,
  input  logic [NUM_LINES-1:0] masked_i,
  input  logic                 ack_i,
  output logic                 take_o,
  output logic [VEC_W-1:0]     vec_o
);
  take_state_e      state_d, state_q;
  logic             take_d, take_q;
  logic [VEC_W-1:0] vec_d, vec_q;
  logic             vec_en;
  logic             may_take;

  assign may_take = glb_ie_i && !dbg_mode_i && any_i;

  always_comb begin
    state_d = state_q;
    take_d  = 1'b0;
    vec_en  = 1'b0;
    vec_d   = idx_i;
    case (state_q)
      TK_IDLE: if (may_take) begin
        take_d  = 1'b1;
        vec_en  = 1'b1;
        state_d = TK_HOLD;
      end
      TK_HOLD: if (ack_i) state_d = TK_IDLE;
      default: state_d = TK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TK_IDLE;
      take_q  <= 1'b0;
      vec_q   <= '0;
    end else begin
      state_q <= state_d;
      take_q  <= take_d;
      if (vec_en) vec_q <= vec_d;
    end
  end

  assign take_o = take_q;
  assign vec_o  = vec_q;

  AST_TAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(glb_ie_i && !dbg_mode_i)); // R4
  AST_VEC_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (($past(masked_i) >> vec_o) == NUM_LINES'(1))); // R5
  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o); // R6
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TK_HOLD && !ack_i) |=> ($stable(vec_o) && !take_o)); // R7
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NUM_SW      = 2,
  parameter int NUM_HW      = 11,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_LINES  = NUM_SW + NUM_HW,
  localparam int VEC_W      = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_HW-1:0]    hw_req_i,
  input  logic                 sw_wr_en_i,
  input  logic [NUM_SW-1:0]    sw_wr_data_i,
  input  logic                 mask_wr_en_i,
  input  logic [NUM_LINES-1:0] mask_wr_data_i,
  input  logic                 glb_ie_i,
  input  logic                 dbg_mode_i,
  input  logic                 ack_i,
  output logic                 take_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic                 wake_o,
  output logic [NUM_LINES-1:0] pend_o
);
  logic [NUM_HW-1:0]    hw_pend;
  logic [NUM_SW-1:0]    sw_pend;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] pend;
  logic [NUM_LINES-1:0] masked;
  logic                 any;
  logic [VEC_W-1:0]     idx;

  irq_sync #(.WIDTH(NUM_HW), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (hw_req_i),
    .sync_o  (hw_pend)
  );

  irq_pend_reg #(.NUM_SW(NUM_SW), .NUM_LINES(NUM_LINES)) u_pend (
    .clk            (clk),
    .rst_n          (rst_n),
    .sw_wr_en_i     (sw_wr_en_i),
    .sw_wr_data_i   (sw_wr_data_i),
    .mask_wr_en_i   (mask_wr_en_i),
    .mask_wr_data_i (mask_wr_data_i),
    .sw_q_o         (sw_pend),
    .mask_q_o       (mask_q)
  );

  assign pend   = {hw_pend, sw_pend};
  assign masked = pend & mask_q;

  irq_prio_enc #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W)) u_enc (
    .masked_i (masked),
    .any_o    (any),
    .idx_o    (idx)
  );

  irq_take_ctrl #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W)) u_take (
    .clk        (clk),
    .rst_n      (rst_n),
    .glb_ie_i   (glb_ie_i),
    .dbg_mode_i (dbg_mode_i),
    .any_i      (any),
    .idx_i      (idx),
    .masked_i   (masked),
    .ack_i      (ack_i),
    .take_o     (take_o),
    .vec_o      (vec_o)
  );

  assign wake_o = any;
  assign pend_o = pend;

  AST_WAKE_BEFORE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(wake_o)); // R8
endmodule

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
  localparam int NL = 13;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [10:0]   hw_req;
  logic          sw_wr_en;
  logic [1:0]    sw_wr_data;
  logic          mask_wr_en;
  logic [NL-1:0] mask_wr_data;
  logic          glb_ie, dbg_mode, ack;
  logic          take_o, wake_o;
  logic [3:0]    vec_o;
  logic [NL-1:0] pend_o;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  bit finished = 0;
  logic prev_take = 1'b0;

  always #5 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .hw_req_i(hw_req),
    .sw_wr_en_i(sw_wr_en), .sw_wr_data_i(sw_wr_data),
    .mask_wr_en_i(mask_wr_en), .mask_wr_data_i(mask_wr_data),
    .glb_ie_i(glb_ie), .dbg_mode_i(dbg_mode), .ack_i(ack),
    .take_o(take_o), .vec_o(vec_o), .wake_o(wake_o), .pend_o(pend_o)
  );

  task automatic chk_eq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard on every take strobe
  always @(negedge clk) begin
    if (rst_n && take_o) begin
      chk_eq("R6 take lasts one cycle", 32'(prev_take), 0);
      if (exp_q.size() == 0) chk_eq("R7 unexpected take", 1, 0);
      else chk_eq("R5 vector", 32'(vec_o), 32'(exp_q.pop_front()));
    end
    prev_take = rst_n ? take_o : 1'b0;
  end

  task automatic sw_write(logic [1:0] d);
    sw_wr_en = 1'b1; sw_wr_data = d;
    @(negedge clk);
    sw_wr_en = 1'b0;
  endtask

  task automatic mask_write(logic [NL-1:0] m);
    mask_wr_en = 1'b1; mask_wr_data = m;
    @(negedge clk);
    mask_wr_en = 1'b0;
  endtask

  task automatic wait_take(string tag);
    bit seen = 0;
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk);
      if (take_o) seen = 1;
    end
    chk_eq(tag, 32'(seen), 1);
  endtask

  task automatic release_vec();
    glb_ie = 1'b0;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [3:0] held;
    rst_n = 1'b0; hw_req = '0; sw_wr_en = 0; sw_wr_data = '0;
    mask_wr_en = 0; mask_wr_data = '0; glb_ie = 0; dbg_mode = 0; ack = 0;
    repeat (3) @(negedge clk);
    chk_eq("R1 pend in reset", 32'(pend_o), 0);
    chk_eq("R1 take in reset", 32'(take_o), 0);
    chk_eq("R1 wake in reset", 32'(wake_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1 pend after reset", 32'(pend_o), 0);

    sw_write(2'b11);
    chk_eq("R3 sw bits set", 32'(pend_o), 32'h3);
    chk_eq("R1 mask cleared so no wake", 32'(wake_o), 0);

    // R2: line 3 -> bit 5, two edges
    hw_req = 11'h008;
    @(negedge clk);
    chk_eq("R2 not after one edge", 32'(pend_o), 32'h3);
    @(negedge clk);
    chk_eq("R2 after two edges", 32'(pend_o), 32'h23);
    hw_req = '0;
    repeat (2) @(negedge clk);
    chk_eq("R2 bit falls with line", 32'(pend_o), 32'h3);

    // R3: software writes leave hardware bits alone
    hw_req = 11'h080;
    repeat (2) @(negedge clk);
    sw_write(2'b01);
    chk_eq("R3 sw write keeps hw bit", 32'(pend_o), 32'h201);
    sw_write(2'b00);
    chk_eq("R3 sw clear keeps hw bit", 32'(pend_o), 32'h200);
    hw_req = '0;
    sw_write(2'b11);
    @(negedge clk);
    chk_eq("R3 sw bits restored", 32'(pend_o), 32'h3);

    // R8/R4: mask open, global enable off, then debug mode
    mask_write('1);
    chk_eq("R8 wake with ie off", 32'(wake_o), 1);
    repeat (3) @(negedge clk);
    chk_eq("R4 no take with ie off", 32'(take_o), 0);
    dbg_mode = 1'b1; glb_ie = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk_eq("R4 no take in debug mode", 32'(take_o), 0);
    end
    chk_eq("R8 wake in debug mode", 32'(wake_o), 1);

    // R5/R6: take with sw bits only -> vector 1
    exp_q.push_back(1);
    dbg_mode = 1'b0;
    wait_take("R4 take when enabled");
    held = vec_o;
    // R7: a higher source appears while held (line 10 -> bit 12)
    hw_req = 11'h400;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk_eq("R7 vector held until ack", 32'(vec_o), 32'(held));
    end
    release_vec();

    exp_q.push_back(12);
    glb_ie = 1'b1;
    wait_take("R5 take of highest source");
    release_vec();

    // R9: only bit 2 enabled; bits 0,1,12 pending -> nothing
    mask_write(13'h0004);
    chk_eq("R9 masked bits give no wake", 32'(wake_o), 0);
    glb_ie = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk_eq("R9 masked bits give no take", 32'(take_o), 0);
    end
    exp_q.push_back(2);
    hw_req = 11'h401;
    wait_take("R9 enabled line 0 taken");
    release_vec();

    // R5: mask hides bit 12, so bit 2 is the top enabled source
    mask_write(13'h0FFF);
    exp_q.push_back(2);
    glb_ie = 1'b1;
    wait_take("R5 take under partial mask");
    release_vec();

    chk_eq("R5 all expected takes seen", 32'(exp_q.size()), 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule